// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sequences the sleep states of a small microcontroller core. Software asks for one of two sleep levels with single-cycle request strobes. In the light level, the processor clock stops and the peripheral clock keeps running. In the deep level, the oscillator is also switched off. The controller drives clock enables for the processor, the peripherals and the oscillator. It also drives a strobe that reinitialises the special-function registers and a signal that blocks on-chip RAM access.

The light level ends on any interrupt that is both pending and enabled, or on the hardware reset input. The deep level ignores interrupts and ends only on hardware reset. When a hardware reset interrupts the light level, the processor keeps running for a fixed number of machine cycles before the reset sequence takes over, and RAM access is blocked during that time. When the deep level ends, the oscillator restarts at once. The processor then stays held for a programmable settling time after reset is released. A two-bit status output reports the current level.

Top module: `lp_power_ctrl`

## Requirements
- R1: A high `idleReq` while running (no reset) gives, from the next cycle, `cpuClkEn`=0, `periphClkEn`=1, `oscEn`=1 and `modeStat`=2'b01. The running state reports `modeStat`=2'b00 with all three clock enables at 1.
- R2: While idle, the block returns to running (`cpuClkEn`=1, `modeStat`=2'b00) in the cycle after some bit i has both `irqPend[i]` and `irqEn[i]` high. A pending bit whose enable is low has no effect.
- R3: A high `pdReq` while running gives, from the next cycle, `cpuClkEn`=0, `periphClkEn`=0, `oscEn`=0 and `modeStat`=2'b10. When `idleReq` and `pdReq` are high together, power-down wins.
- R4: In power-down, interrupts and further requests are ignored. Only `hwReset` leaves the state.
- R5: A high `hwReset` while running (or together with a request) gives, from the next cycle and for as long as it is held, `sfrInit`=1, `cpuClkEn`=0 and `oscEn`=1. Requests are ignored during this time. After release the block runs on the next cycle.
- R6: A `hwReset` arriving while idle takes priority over interrupts. It opens a window of CYC_PER_MC*WIN_MC cycles (24 by default) with `cpuClkEn`=1, `ramInhibit`=1 and `sfrInit`=0. The window runs in full even if reset is released early. After it, `sfrInit`=1 for at least one cycle and for as long as reset is held.
- R7: A `hwReset` in power-down sets `oscEn`=1 and `sfrInit`=1 on the next cycle. After release, STAB_CYCLES cycles follow with `oscEn`=1, `cpuClkEn`=0 and `periphClkEn`=0, and then the block runs. A reset during this settling time restarts it from the beginning.
- R8: `ramInhibit` is high only inside the window of R6, and never for more than CYC_PER_MC*WIN_MC consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| hwReset | input | 1 | Hardware reset, active high, sampled on clk |
| idleReq | input | 1 | Software request for the light sleep level |
| pdReq | input | 1 | Software request for the deep sleep level |
| irqPend | input | NUM_IRQ | Interrupt pending flags |
| irqEn | input | NUM_IRQ | Interrupt enable flags |
| cpuClkEn | output | 1 | Processor clock enable |
| periphClkEn | output | 1 | Peripheral clock enable |
| oscEn | output | 1 | Oscillator enable |
| sfrInit | output | 1 | Special-function register reinitialise strobe |
| ramInhibit | output | 1 | Blocks on-chip RAM access |
| modeStat | output | 2 | 00 run, 01 idle, 10 power-down |

## Verification
The hardest case to reach from the ports is a reset that ends the light level but is released before the machine-cycle window closes. The window must still run its full length and then pass through one reset cycle. A second hard case is a reset that lands partway through the settling time after power-down, which must restart the count. The stimulus reaches both cases with planned sequences. It first enters the sleep level through a request, then holds or drops reset at exact cycle counts, and it expects the window, the reset and the settling phases cycle by cycle.

// File: rtl/lp_pkg.sv
package lp_pkg;

  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_IDLE  = 3'd1,
    ST_PDOWN = 3'd2,
    ST_WIN   = 3'd3,
    ST_RST   = 3'd4,
    ST_PDRST = 3'd5,
    ST_STAB  = 3'd6
  } lpState_t;

  // strobes from control to the countdown datapath
  typedef struct packed {
    logic loadWin;
    logic loadStab;
  } cntCtl_t;

  localparam logic [1:0] MODE_RUN  = 2'b00;
  localparam logic [1:0] MODE_IDLE = 2'b01;
  localparam logic [1:0] MODE_PD   = 2'b10;

endpackage

// File: rtl/lp_datapath.sv
module lp_datapath #(
  parameter int NUM_IRQ     = 5,
  parameter int WIN_LEN     = 24,
  parameter int STAB_CYCLES = 64
) (
  input  logic               clk,
  input  lp_pkg::cntCtl_t    ctl,
  input  logic [NUM_IRQ-1:0] irqPend,
  input  logic [NUM_IRQ-1:0] irqEn,
  output logic               wakeHit,
  output logic               cntDone
);
  localparam int MAXC  = (WIN_LEN > STAB_CYCLES) ? WIN_LEN : STAB_CYCLES;
  localparam int CNT_W = (MAXC < 2) ? 1 : $clog2(MAXC);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (ctl.loadWin)       cnt <= CNT_W'(WIN_LEN - 1);
    else if (ctl.loadStab) cnt <= CNT_W'(STAB_CYCLES - 1);
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign cntDone = (cnt == '0);
  assign wakeHit = |(irqPend & irqEn);

endmodule

// File: rtl/lp_control.sv
module lp_control (
  input  logic            clk,
  input  logic            hwReset,
  input  logic            idleReq,
  input  logic            pdReq,
  input  logic            wakeHit,
  input  logic            cntDone,
  output lp_pkg::cntCtl_t ctl,
  output logic            cpuClkEn,
  output logic            periphClkEn,
  output logic            oscEn,
  output logic            sfrInit,
  output logic            ramInhibit,
  output logic [1:0]      modeStat
);
  import lp_pkg::*;

  lpState_t state, nxt;

  always_comb begin
    nxt = state;
    ctl = '0;
    unique case (state)
      ST_RUN: begin
        if (hwReset)      nxt = ST_RST;
        else if (pdReq)   nxt = ST_PDOWN;
        else if (idleReq) nxt = ST_IDLE;
      end
      ST_IDLE: begin
        if (hwReset) begin
          nxt = ST_WIN;
          ctl.loadWin = 1'b1;
        end else if (wakeHit) nxt = ST_RUN;
      end
      ST_PDOWN: if (hwReset) nxt = ST_PDRST;
      ST_WIN:   if (cntDone) nxt = ST_RST;
      ST_RST:   if (!hwReset) nxt = ST_RUN;
      ST_PDRST: begin
        if (!hwReset) begin
          nxt = ST_STAB;
          ctl.loadStab = 1'b1;
        end
      end
      ST_STAB: begin
        if (hwReset)      nxt = ST_PDRST;
        else if (cntDone) nxt = ST_RUN;
      end
      default: nxt = hwReset ? ST_RST : ST_RUN;
    endcase
  end

  always_ff @(posedge clk) state <= nxt;

  always_comb begin
    cpuClkEn    = 1'b0;
    periphClkEn = 1'b1;
    oscEn       = 1'b1;
    sfrInit     = 1'b0;
    ramInhibit  = 1'b0;
    modeStat    = MODE_RUN;
    unique case (state)
      ST_RUN:   cpuClkEn = 1'b1;
      ST_IDLE:  modeStat = MODE_IDLE;
      ST_PDOWN: begin
        periphClkEn = 1'b0;
        oscEn       = 1'b0;
        modeStat    = MODE_PD;
      end
      ST_WIN: begin
        cpuClkEn   = 1'b1;
        ramInhibit = 1'b1;
      end
      ST_RST, ST_PDRST: sfrInit = 1'b1;
      ST_STAB:  periphClkEn = 1'b0;
      default:  sfrInit = 1'b1;
    endcase
  end

endmodule

// File: rtl/lp_power_ctrl.sv
module lp_power_ctrl #(
  parameter int NUM_IRQ     = 5,
  parameter int CYC_PER_MC  = 12,
  parameter int WIN_MC      = 2,
  parameter int STAB_CYCLES = 64
) (
  input  logic               clk,
  input  logic               hwReset,
  input  logic               idleReq,
  input  logic               pdReq,
  input  logic [NUM_IRQ-1:0] irqPend,
  input  logic [NUM_IRQ-1:0] irqEn,
  output logic               cpuClkEn,
  output logic               periphClkEn,
  output logic               oscEn,
  output logic               sfrInit,
  output logic               ramInhibit,
  output logic [1:0]         modeStat
);
  localparam int WIN_LEN = CYC_PER_MC * WIN_MC;

  lp_pkg::cntCtl_t ctl;
  logic wakeHit, cntDone;

  lp_control ctrl_i (
    .clk(clk), .hwReset(hwReset), .idleReq(idleReq), .pdReq(pdReq),
    .wakeHit(wakeHit), .cntDone(cntDone), .ctl(ctl),
    .cpuClkEn(cpuClkEn), .periphClkEn(periphClkEn), .oscEn(oscEn),
    .sfrInit(sfrInit), .ramInhibit(ramInhibit), .modeStat(modeStat)
  );

  lp_datapath #(
    .NUM_IRQ(NUM_IRQ), .WIN_LEN(WIN_LEN), .STAB_CYCLES(STAB_CYCLES)
  ) dp_i (
    .clk(clk), .ctl(ctl), .irqPend(irqPend), .irqEn(irqEn),
    .wakeHit(wakeHit), .cntDone(cntDone)
  );

endmodule

// File: rtl/lp_power_ctrl_chk.sv
module lp_power_ctrl_chk #(
  parameter int NUM_IRQ = 5,
  parameter int WIN_LEN = 24
) (
  input logic               clk,
  input logic               hwReset,
  input logic               idleReq,
  input logic               pdReq,
  input logic [NUM_IRQ-1:0] irqPend,
  input logic [NUM_IRQ-1:0] irqEn,
  input logic               cpuClkEn,
  input logic               periphClkEn,
  input logic               oscEn,
  input logic               sfrInit,
  input logic               ramInhibit,
  input logic [1:0]         modeStat
);
  logic [15:0] inhRun = '0;

  always_ff @(posedge clk) begin
    inhRun <= ramInhibit ? inhRun + 16'd1 : 16'd0;
    if (ramInhibit)
      assert_win_len_R8: assert (inhRun < 16'(WIN_LEN))
        else $error("ramInhibit held beyond window");
  end

  assert_idle_entry_R1: assert property (@(posedge clk) disable iff (hwReset)
    (modeStat == 2'b00 && cpuClkEn && !ramInhibit && idleReq && !pdReq)
      |=> (modeStat == 2'b01 && !cpuClkEn && periphClkEn));

  assert_idle_wake_R2: assert property (@(posedge clk) disable iff (hwReset)
    (modeStat == 2'b01 && |(irqPend & irqEn)) |=> (modeStat == 2'b00 && cpuClkEn));

  assert_pd_clocks_R3: assert property (@(posedge clk) disable iff (hwReset)
    (modeStat == 2'b10) |-> (!oscEn && !periphClkEn && !cpuClkEn));

  assert_pd_sticky_R4: assert property (@(posedge clk) disable iff (hwReset)
    (modeStat == 2'b10) |=> (modeStat == 2'b10));

  assert_sfr_hold_R5: assert property (@(posedge clk) disable iff (hwReset)
    sfrInit |-> (!cpuClkEn && oscEn && !ramInhibit));

  assert_win_cpu_R6: assert property (@(posedge clk) disable iff (hwReset)
    ramInhibit |-> (cpuClkEn && !sfrInit));

endmodule

bind lp_power_ctrl lp_power_ctrl_chk #(
  .NUM_IRQ(NUM_IRQ), .WIN_LEN(CYC_PER_MC * WIN_MC)
) chk_i (
  .clk(clk), .hwReset(hwReset), .idleReq(idleReq), .pdReq(pdReq),
  .irqPend(irqPend), .irqEn(irqEn), .cpuClkEn(cpuClkEn),
  .periphClkEn(periphClkEn), .oscEn(oscEn), .sfrInit(sfrInit),
  .ramInhibit(ramInhibit), .modeStat(modeStat)
);

// File: tb/lp_power_ctrl_tb.sv
`timescale 1ns/1ps
module lp_power_ctrl_tb_top;
  localparam int NIRQ = 5;
  localparam int STAB = 64;
  localparam int WIN  = 24;

  // {cpu, periph, osc, sfr, ram, mode[1:0]}
  localparam logic [6:0] RUNV  = 7'b1110000;
  localparam logic [6:0] IDLEV = 7'b0110001;
  localparam logic [6:0] PDV   = 7'b0000010;
  localparam logic [6:0] RSTV  = 7'b0111000;
  localparam logic [6:0] WINV  = 7'b1110100;
  localparam logic [6:0] STABV = 7'b0010000;

  logic clk = 1'b0;
  logic hwReset = 1'b1, idleReq = 1'b0, pdReq = 1'b0;
  logic [NIRQ-1:0] irqPend = '0, irqEn = '0;
  logic cpuClkEn, periphClkEn, oscEn, sfrInit, ramInhibit;
  logic [1:0] modeStat;

  typedef struct { logic [6:0] v; string tag; } expItem_t;
  expItem_t q[$];
  int vecCnt = 0, errCnt = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lp_power_ctrl #(.NUM_IRQ(NIRQ), .CYC_PER_MC(12), .WIN_MC(2), .STAB_CYCLES(STAB)) dut_i (
    .clk(clk), .hwReset(hwReset), .idleReq(idleReq), .pdReq(pdReq),
    .irqPend(irqPend), .irqEn(irqEn), .cpuClkEn(cpuClkEn),
    .periphClkEn(periphClkEn), .oscEn(oscEn), .sfrInit(sfrInit),
    .ramInhibit(ramInhibit), .modeStat(modeStat)
  );

  // monitor: compare one expected item per edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      expItem_t it;
      logic [6:0] act;
      it = q.pop_front();
      act = {cpuClkEn, periphClkEn, oscEn, sfrInit, ramInhibit, modeStat};
      vecCnt++;
      if (act !== it.v) begin
        errCnt++;
        $display("FAIL %s: actual %b expected %b", it.tag, act, it.v);
      end
    end
  end

  task automatic step(input logic r, input logic iq, input logic pq,
                      input logic [NIRQ-1:0] pend, input logic [NIRQ-1:0] en,
                      input logic [6:0] ev, input string tag);
    expItem_t it;
    @(negedge clk);
    hwReset = r; idleReq = iq; pdReq = pq; irqPend = pend; irqEn = en;
    it.v = ev; it.tag = tag;
    q.push_back(it);
  endtask

  initial begin
    step(1, 0, 0, '0, '0, RSTV, "R5 reset state");
    step(1, 1, 1, '0, '0, RSTV, "R5 requests ignored in reset");
    step(0, 0, 0, '0, '0, RUNV, "R5 release to run");
    step(0, 0, 0, '0, '0, RUNV, "R1 run steady");
    // idle entry and wake
    step(0, 1, 0, '0, '0, IDLEV, "R1 enter idle");
    step(0, 0, 0, 5'b00101, 5'b01010, IDLEV, "R2 unenabled pending ignored");
    step(0, 0, 0, 5'b00100, 5'b00100, RUNV, "R2 enabled wake");
    step(0, 1, 0, 5'b00001, 5'b00001, IDLEV, "R1 idle with pending");
    step(0, 0, 0, 5'b00001, 5'b00001, RUNV, "R2 immediate wake");
    // power-down
    step(0, 1, 1, '0, '0, PDV, "R3 pd beats idle");
    step(0, 0, 0, 5'h1f, 5'h1f, PDV, "R4 irq ignored in pd");
    step(0, 1, 0, '0, '0, PDV, "R4 idle request ignored in pd");
    step(0, 0, 0, '0, '0, PDV, "R4 pd holds");
    step(1, 0, 0, '0, '0, RSTV, "R7 reset restarts osc");
    step(1, 0, 0, '0, '0, RSTV, "R7 reset held");
    for (int i = 0; i < STAB; i++) step(0, 0, 0, '0, '0, STABV, "R7 settling");
    step(0, 0, 0, '0, '0, RUNV, "R7 run after settling");
    // reset during settling
    step(0, 0, 1, '0, '0, PDV, "R3 pd entry");
    step(1, 0, 0, '0, '0, RSTV, "R7 reset in pd");
    for (int i = 0; i < 10; i++) step(0, 0, 0, '0, '0, STABV, "R7 partial settling");
    step(1, 0, 0, '0, '0, RSTV, "R7 reset in settling");
    for (int i = 0; i < STAB; i++) step(0, 0, 0, '0, '0, STABV, "R7 settling restarted");
    step(0, 0, 0, '0, '0, RUNV, "R7 run after restart");
    // reset out of idle, held
    step(0, 1, 0, '0, '0, IDLEV, "R1 enter idle");
    for (int i = 0; i < WIN; i++) step(1, 0, 0, 5'b00010, 5'b00010, WINV, "R6 window, reset beats irq");
    for (int i = 0; i < 3; i++) step(1, 0, 0, '0, '0, RSTV, "R6 reset after window");
    step(0, 0, 0, '0, '0, RUNV, "R6 release to run");
    // reset out of idle, released early
    step(0, 1, 0, '0, '0, IDLEV, "R1 enter idle");
    for (int i = 0; i < 3; i++) step(1, 0, 0, '0, '0, WINV, "R6 window start");
    for (int i = 0; i < WIN - 3; i++) step(0, 0, 0, '0, '0, WINV, "R8 window completes");
    step(0, 0, 0, '0, '0, RSTV, "R6 one reset cycle");
    step(0, 0, 0, '0, '0, RUNV, "R8 inhibit cleared");
    // reset beats idle request in run
    step(1, 1, 0, '0, '0, RSTV, "R5 reset over idle request");
    step(0, 0, 0, '0, '0, RUNV, "R5 release");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errCnt++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
      $finish;
    end
  end

endmodule